// File: doc/BRIEF.md
# Memory Test Access Port

This block is the boundary-scan test port of a synchronous memory device. A tester drives a test clock, a mode-select line and a serial data input, and may pull an asynchronous active-low reset. A sixteen-state controller walks through the standard capture, shift and update phases. A 3-bit instruction decides which data register sits between the serial input and the serial output. The data registers are a 1-bit bypass cell, a 32-bit device identity word and a boundary chain of capture cells. The boundary chain is 89 cells long by default and can be set to 85 for the smaller package.

Two of the instructions also raise a disable line that puts the memory's data drivers into high impedance. The boundary cells only capture the parallel pin-value bus and shift it out. No instruction drives a pin from the chain; the disable line is the only effect the port has on the memory. The memory array and the pad drivers lie outside this block.

Top module: `memtap_top`

## Requirements
- R1: While `test_rst_n` is low the port is held in its reset state without a clock: the active instruction is the identity code 001, `mem_out_hiz` is 0 and `scan_out_en` is 0. After release the controller starts in Test-Logic-Reset.
- R2: Five consecutive rising clock edges with `mode_sel` high bring the controller to Test-Logic-Reset from any state. Entering that state restores instruction 001 and clears `mem_out_hiz`.
- R3: The instruction register is 3 bits wide. In Capture-IR it loads 3'b001. It shifts with bit 0 leaving first and `scan_in` entering at bit 2.
- R4: A newly shifted instruction, and its effect on `mem_out_hiz`, take hold only at the Update-IR edge. They then hold until the next Update-IR or reset.
- R5: Code 001 selects a 32-bit register that captures the identity word. From bit 31 down to bit 0 its fields are: revision 000, depth 01011, architecture 000110, device code 010101, manufacturer code 00000110100, and a final 1.
- R6: Code 111 selects the 1-bit bypass register, which captures 0. The unused codes 011, 101 and 110 behave exactly like 111.
- R7: Codes 000, 010 and 100 select the boundary chain of `BSR_LEN` cells. In Capture-DR it loads `pin_values`. It shifts out with bit 0 first, and `scan_in` enters at the top cell.
- R8: `mem_out_hiz` is 1 while the active instruction is 000 or 010, and 0 for every other code.
- R9: `scan_in` is sampled on the rising edge and `scan_out` changes on the falling edge. `scan_out_en` is 1 only for the half-cycles that follow a falling edge in Shift-DR or Shift-IR, and `scan_out` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low port reset |
| mode_sel | input | 1 | Controller state-steering input, sampled on the rising edge |
| scan_in | input | 1 | Serial data input |
| pin_values | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| scan_out | output | 1 | Serial data output, updated on the falling edge |
| scan_out_en | output | 1 | High while `scan_out` carries shifted data |
| mem_out_hiz | output | 1 | Forces the memory's data drivers to high impedance |

## Verification
Two events can fall in the same cycle: the boundary chain capturing the pin bus and the output disable being held by the active instruction. Under the pin-test instruction, the bench changes `pin_values` on the falling edge just before the Capture-DR rising edge. It then requires that the newly driven value, not the earlier one, shifts out bit for bit, and that `mem_out_hiz` stays high through that scan. A second overlap puts an Update-IR close to a high-impedance change. The bench checks that the disable line does not move while the new code is still being shifted, or while the controller sits in Update-IR, and that it moves on the edge that leaves Update-IR.

// File: rtl/memtap_pkg.sv
package memtap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  localparam int          IR_W        = 3;
  localparam logic [2:0]  OP_PINTEST  = 3'b000;
  localparam logic [2:0]  OP_IDENT    = 3'b001;
  localparam logic [2:0]  OP_SAMPLEZ  = 3'b010;
  localparam logic [2:0]  OP_SAMPLE   = 3'b100;
  localparam logic [2:0]  OP_BYPASS   = 3'b111;
  localparam logic [2:0]  IR_CAPTURE  = 3'b001;

  localparam logic [2:0]  ID_REV    = 3'b000;
  localparam logic [4:0]  ID_DEPTH  = 5'b01011;
  localparam logic [5:0]  ID_ARCH   = 6'b000110;
  localparam logic [5:0]  ID_DEV    = 6'b010101;
  localparam logic [10:0] ID_MFR    = 11'b00000110100;

  function automatic logic [31:0] id_word();
    return {ID_REV, ID_DEPTH, ID_ARCH, ID_DEV, ID_MFR, 1'b1};
  endfunction

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_path_e path_of(logic [2:0] op);
    case (op)
      OP_IDENT:                         return PATH_ID;
      OP_PINTEST, OP_SAMPLEZ, OP_SAMPLE: return PATH_BSR;
      default:                          return PATH_BYP;
    endcase
  endfunction

  function automatic logic hiz_of(logic [2:0] op);
    return (op == OP_PINTEST) || (op == OP_SAMPLEZ);
  endfunction

endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
  import memtap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  output tap_state_e state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= tap_next(state, mode_sel);
  end

endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
  import memtap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            scan_in,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_cur,
  output logic            out_hiz
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sh <= {scan_in, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_cur  <= OP_IDENT;
      out_hiz <= 1'b0;
    end else if (state == ST_RESET) begin
      ir_cur  <= OP_IDENT;
      out_hiz <= 1'b0;
    end else if (state == ST_UPD_IR) begin
      ir_cur  <= ir_sh;
      out_hiz <= hiz_of(ir_sh);
    end
  end

endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
  import memtap_pkg::*;
#(
  parameter int BSR_LEN = 89
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  dr_path_e           path,
  input  logic               scan_in,
  input  logic [BSR_LEN-1:0] pin_values,
  output logic               dr_bit
);

  localparam int ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;

  logic cap_now, sh_now;
  assign cap_now = (state == ST_CAP_DR);
  assign sh_now  = (state == ST_SH_DR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else begin
      case (path)
        PATH_ID: begin
          if (cap_now)     id_q <= id_word();
          else if (sh_now) id_q <= {scan_in, id_q[ID_W-1:1]};
        end
        PATH_BSR: begin
          if (cap_now)     bsr_q <= pin_values;
          else if (sh_now) bsr_q <= {scan_in, bsr_q[BSR_LEN-1:1]};
        end
        default: begin
          if (cap_now)     byp_q <= 1'b0;
          else if (sh_now) byp_q <= scan_in;
        end
      endcase
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_bit = id_q[0];
      PATH_BSR: dr_bit = bsr_q[0];
      default:  dr_bit = byp_q;
    endcase
  end

endmodule

// File: rtl/memtap_top.sv
module memtap_top
  import memtap_pkg::*;
#(
  parameter int BSR_LEN = 89
) (
  input  logic               test_clk,
  input  logic               test_rst_n,
  input  logic               mode_sel,
  input  logic               scan_in,
  input  logic [BSR_LEN-1:0] pin_values,
  output logic               scan_out,
  output logic               scan_out_en,
  output logic               mem_out_hiz
);

  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_cur;
  dr_path_e        sel_path;
  logic            dr_bit;
  logic            shifting;

  memtap_fsm u_fsm (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .mode_sel (mode_sel),
    .state    (tap_state)
  );

  memtap_ir u_ir (
    .clk     (test_clk),
    .rst_n   (test_rst_n),
    .state   (tap_state),
    .scan_in (scan_in),
    .ir_sh   (ir_sh),
    .ir_cur  (ir_cur),
    .out_hiz (mem_out_hiz)
  );

  assign sel_path = path_of(ir_cur);

  memtap_dr #(.BSR_LEN(BSR_LEN)) u_dr (
    .clk        (test_clk),
    .rst_n      (test_rst_n),
    .state      (tap_state),
    .path       (sel_path),
    .scan_in    (scan_in),
    .pin_values (pin_values),
    .dr_bit     (dr_bit)
  );

  assign shifting = (tap_state == ST_SH_DR) || (tap_state == ST_SH_IR);

  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) begin
      scan_out    <= 1'b0;
      scan_out_en <= 1'b0;
    end else begin
      scan_out_en <= shifting;
      scan_out    <= shifting ? ((tap_state == ST_SH_IR) ? ir_sh[0] : dr_bit) : 1'b0;
    end
  end

endmodule

// File: rtl/memtap_checks.sv
module memtap_checks
  import memtap_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mode_sel,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sh,
  input logic [IR_W-1:0] ir_cur,
  input logic            out_hiz,
  input logic            tdo_en
);

  logic [2:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        high_run <= '0;
    else if (!mode_sel) high_run <= '0;
    else if (high_run != 3'd5) high_run <= high_run + 3'd1;
  end

  p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir_cur == OP_IDENT) && !out_hiz);

  p_five_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (high_run == 3'd5) |-> (state == ST_RESET));

  p_capture_ir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_cur) && $stable(out_hiz));

  p_hiz_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UPD_IR) |=> out_hiz == (($past(ir_sh) == OP_PINTEST) || ($past(ir_sh) == OP_SAMPLEZ)));

  p_tdo_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind memtap_top memtap_checks u_checks (
  .clk      (test_clk),
  .rst_n    (test_rst_n),
  .mode_sel (mode_sel),
  .state    (tap_state),
  .ir_sh    (ir_sh),
  .ir_cur   (ir_cur),
  .out_hiz  (mem_out_hiz),
  .tdo_en   (scan_out_en)
);

// File: tb/memtap_top_bench.sv
module memtap_top_bench;
  localparam int L = 89;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [L-1:0] pins = '0;
  logic tdo, tdo_en, hiz;

  always #2 clk = ~clk;

  memtap_top #(.BSR_LEN(L)) u_memtap_top (
    .test_clk    (clk),
    .test_rst_n  (rst_n),
    .mode_sel    (tms),
    .scan_in     (tdi),
    .pin_values  (pins),
    .scan_out    (tdo),
    .scan_out_en (tdo_en),
    .mem_out_hiz (hiz)
  );

  typedef struct {
    logic  b;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] ID_EXP = {3'b000, 5'b01011, 6'b000110, 6'b010101, 11'b00000110100, 1'b1};

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic b, string tag);
    exp_t x;
    x.b = b;
    x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: every enabled output half-cycle must match the next queued bit
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (tdo_en === 1'b1) begin
        n_run++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected shift output actual=%0b expected=none", tdo);
        end else begin
          e = q.pop_front();
          if (tdo !== e.b) begin
            n_fail++;
            $display("FAIL %s serial bit actual=%0b expected=%0b", e.tag, tdo, e.b);
          end
        end
      end
    end
  end

  task automatic step(logic m, logic d);
    @(negedge clk);
    tms = m;
    tdi = d;
    @(posedge clk);
    #1;
  endtask

  task automatic load_ir(logic [2:0] code);
    logic prev;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    prev = hiz;
    for (int i = 0; i < 3; i++) begin
      push((i == 0), "R3");
      step(i == 2, code[i]);
    end
    chk(hiz === prev, "R4 hiz moved before update", hiz, prev);
    step(1'b1, 1'b0);
    chk(hiz === prev, "R4 hiz moved in Update-IR", hiz, prev);
    step(1'b0, 1'b0);
  endtask

  task automatic scan_dr(int n, logic [127:0] din, logic [127:0] exp, string tag,
                         bit np_valid, logic [L-1:0] np);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    tms = 1'b0;
    tdi = 1'b0;
    if (np_valid) pins = np;
    @(posedge clk);
    #1;
    for (int i = 0; i < n; i++) begin
      push(exp[i], tag);
      step(i == n - 1, din[i]);
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk(q.size() == 0, "R9 shift count", q.size(), 0);
  endtask

  logic [L-1:0] pat_a;
  logic [127:0] bexp;

  initial begin
    pat_a = L'({32'hA5C3_1E69, 32'h0F1E_2D3C, 32'h9B8A_7766});
    pins  = pat_a;
    #9;
    // R1: reset state
    chk(hiz === 1'b0, "R1 hiz in reset", hiz, 0);
    chk(tdo_en === 1'b0, "R1 tdo_en in reset", tdo_en, 0);
    chk(tdo === 1'b0, "R9 tdo idle", tdo, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);

    // R1/R5: identity selected after reset
    scan_dr(32, '0, 128'(ID_EXP), "R5", 1'b0, '0);

    // R6: bypass one-bit delay
    load_ir(3'b111);
    chk(hiz === 1'b0, "R8 bypass hiz", hiz, 0);
    scan_dr(8, 128'h000000000000000000000000000000B5, 128'h0000000000000000000000000000006A, "R6", 1'b0, '0);

    // R6: reserved codes behave as bypass
    load_ir(3'b011);
    scan_dr(4, 128'h6, 128'hC, "R6 code011", 1'b0, '0);
    load_ir(3'b101);
    scan_dr(4, 128'h3, 128'h6, "R6 code101", 1'b0, '0);
    load_ir(3'b110);
    chk(hiz === 1'b0, "R8 reserved hiz", hiz, 0);
    scan_dr(4, 128'h9, 128'h2, "R6 code110", 1'b0, '0);

    // R7: sample/preload, no disable
    load_ir(3'b100);
    chk(hiz === 1'b0, "R8 sample hiz", hiz, 0);
    scan_dr(L, '0, 128'(pat_a), "R7 sample", 1'b0, '0);

    // R8/R7: pin test with pins changed on the capture edge
    load_ir(3'b000);
    chk(hiz === 1'b1, "R8 pintest hiz", hiz, 1);
    scan_dr(L, '0, 128'(~pat_a), "R7 same-cycle capture", 1'b1, ~pat_a);
    chk(hiz === 1'b1, "R4 hiz held across scan", hiz, 1);

    // R8: sample-z, then identity releases the disable only at update
    load_ir(3'b010);
    chk(hiz === 1'b1, "R8 samplez hiz", hiz, 1);
    pins = pat_a;
    scan_dr(L, '0, 128'(pat_a), "R7 samplez", 1'b0, '0);
    load_ir(3'b001);
    chk(hiz === 1'b0, "R8 ident hiz", hiz, 0);
    scan_dr(32, '0, 128'(ID_EXP), "R5 reload", 1'b0, '0);

    // R2: five high cycles from idle
    load_ir(3'b000);
    chk(hiz === 1'b1, "R8 pintest hiz again", hiz, 1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    chk(hiz === 1'b0, "R2 hiz after tms reset", hiz, 0);
    step(1'b0, 1'b0);
    scan_dr(32, '0, 128'(ID_EXP), "R2 ident after tms reset", 1'b0, '0);

    // R2: five high cycles starting inside Shift-DR
    load_ir(3'b111);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    push(1'b0, "R2 bypass bit");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    scan_dr(32, '0, 128'(ID_EXP), "R2 ident after shift reset", 1'b0, '0);

    // R1: asynchronous reset with the disable active
    load_ir(3'b000);
    chk(hiz === 1'b1, "R8 pintest before async reset", hiz, 1);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk(hiz === 1'b0, "R1 async hiz", hiz, 0);
    chk(tdo_en === 1'b0, "R1 async tdo_en", tdo_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    scan_dr(32, '0, 128'(ID_EXP), "R1 ident after async reset", 1'b0, '0);

    bexp = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule